// File: doc/BRIEF.md
# Memory-Mapped Chip-Select Decoder

This block watches a 24-bit address bus and its two active-low bus strobes (read and write). From them it produces the active-low control lines for four devices: a 64K x 8 ROM, a 1M x 8 RAM, a byte-wide input port and a byte-wide output port. The ROM and the RAM are fully decoded on their upper address bits. The output port is partially decoded on the top nibble only. The input port is decoded on both the top nibble and the low byte, and the twelve bits in between are ignored.

The selects and enables are purely combinational, and the address is never latched. Each device receives only the controls it actually has:
- ROM: chip select and output enable.
- RAM: chip select, output enable and write enable.
- Input port: output enable only.
- Output port: write strobe only.

A clocked, sticky error flag records any strobe that hits no device. It can be removed with a parameter.

Top module: `chip_select_decoder`

## Requirements
- R1: A read (rdN=0, wrN=1) with addr[23:16] = 0x04 (0x040000..0x04FFFF) drives romCsN and romOeN low. Addresses outside that range leave both high.
- R2: A write never asserts romCsN or romOeN, not even inside the ROM range.
- R3: With addr[23:20] = 0xA (0xA00000..0xAFFFFF), a read drives ramCsN and ramOeN low, and a write drives ramCsN and ramWeN low. ramOeN stays high on writes, and ramWeN stays high on reads.
- R4: A read with addr[23:20] = 0xF and addr[7:0] = 0x00 drives inOeN low, whatever the value of addr[19:8]. A write to the same pattern leaves inOeN high, and a nonzero low byte also leaves it high.
- R5: A write with addr[23:20] = 0x1 drives outWrN low, whatever the value of addr[19:0]. A read from that range leaves outWrN high.
- R6: While both strobes are high, every device control output is high.
- R7: While both strobes are low at once, every device control output is high.
- R8: At most one device is enabled at any time.
- R9: On the clock edge that follows a strobe (either strobe low) on an address that matches no device, errFlag goes high one cycle later and stays high until the synchronous active-high reset rst. A strobe on a mapped address does not set it, and rst clears it to 0.
- R10: The control outputs follow changes of address and strobes between clock edges, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the error flag |
| rst | input | 1 | Synchronous active-high reset of the error flag |
| addr | input | 24 | Bus address |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| romCsN | output | 1 | ROM chip select, active low |
| romOeN | output | 1 | ROM output enable, active low |
| ramCsN | output | 1 | RAM chip select, active low |
| ramOeN | output | 1 | RAM output enable, active low |
| ramWeN | output | 1 | RAM write enable, active low |
| inOeN | output | 1 | Input port output enable, active low |
| outWrN | output | 1 | Output port write strobe, active low |
| errFlag | output | 1 | Sticky unmapped-access flag |

## Verification
Each region is hit at its first and last address and at the addresses one below and one above. This separates exact decoding from decoding that is one bit too wide or too narrow. The input port pattern is tried with scattered middle bits and with a nonzero low byte, which tells the ignored bits apart from the decoded ones. Every address is driven as a read, as a write, with both strobes idle and with both strobes low, so a control wired to the wrong strobe shows up. The flag is set from an unmapped address and then shown to hold through idle cycles and mapped accesses until reset.

// File: rtl/csdec_pkg.sv
package csdec_pkg;
  localparam int ADDR_W  = 24;
  localparam int NUM_DEV = 4;
  localparam int DEV_ROM = 0;
  localparam int DEV_RAM = 1;
  localparam int DEV_IN  = 2;
  localparam int DEV_OUT = 3;

  // Bits that take part in each device's compare, and the value they must hold
  localparam logic [ADDR_W-1:0] DEV_MASK  [NUM_DEV] = '{24'hFF0000, 24'hF00000, 24'hF000FF, 24'hF00000};
  localparam logic [ADDR_W-1:0] DEV_MATCH [NUM_DEV] = '{24'h040000, 24'hA00000, 24'hF00000, 24'h100000};

  // Active-high control strobes from control to datapath/top
  typedef struct packed {
    logic romCs;
    logic romOe;
    logic ramCs;
    logic ramOe;
    logic ramWe;
    logic inOe;
    logic outWr;
    logic errSet;
  } ctrlT;
endpackage

// File: rtl/cs_region_match.sv
module cs_region_match #(
  parameter int W = 24,
  parameter logic [W-1:0] MASK  = '0,
  parameter logic [W-1:0] VALUE = '0
) (
  input  logic [W-1:0] addr,
  output logic         hit
);
  assign hit = ((addr & MASK) == VALUE);
endmodule

// File: rtl/cs_datapath.sv
module cs_datapath
  import csdec_pkg::*;
#(
  parameter bit ERR_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  ctrlT              ctrl,
  output logic [NUM_DEV-1:0] hit,
  output logic              errFlag
);
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_match
    cs_region_match #(.W(ADDR_W), .MASK(DEV_MASK[d]), .VALUE(DEV_MATCH[d])) u_match (
      .addr(addr),
      .hit (hit[d])
    );
  end

  if (ERR_EN) begin : g_err
    logic errQ;
    always_ff @(posedge clk) begin
      if (rst) errQ <= 1'b0;
      else     errQ <= errQ | ctrl.errSet;
    end
    assign errFlag = errQ;

    assert_err_set_R9: assert property (@(posedge clk) disable iff (rst)
      ctrl.errSet |=> errFlag);
    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      errFlag |=> errFlag);
  end else begin : g_noerr
    assign errFlag = 1'b0;
  end
endmodule

// File: rtl/cs_control.sv
module cs_control
  import csdec_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DEV-1:0] hit,
  input  logic               rdN,
  input  logic               wrN,
  output ctrlT               ctrl
);
  logic rdOnly, wrOnly, anyStrobe;

  always_comb begin
    rdOnly    = !rdN && wrN;
    wrOnly    = rdN && !wrN;
    anyStrobe = !rdN || !wrN;
    ctrl.romCs  = hit[DEV_ROM] && rdOnly;
    ctrl.romOe  = hit[DEV_ROM] && rdOnly;
    ctrl.ramCs  = hit[DEV_RAM] && (rdOnly || wrOnly);
    ctrl.ramOe  = hit[DEV_RAM] && rdOnly;
    ctrl.ramWe  = hit[DEV_RAM] && wrOnly;
    ctrl.inOe   = hit[DEV_IN]  && rdOnly;
    ctrl.outWr  = hit[DEV_OUT] && wrOnly;
    ctrl.errSet = anyStrobe && (hit == '0);
  end

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (rdN && wrN) |-> (ctrl[7:1] == '0));
  assert_both_low_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (!rdN && !wrN) |-> (ctrl[7:1] == '0));
  assert_rom_no_write_R2: assert property (@(posedge clk) disable iff (rst)
    !wrN |-> (!ctrl.romCs && !ctrl.romOe));
  assert_single_device_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.romCs, ctrl.ramCs, ctrl.inOe, ctrl.outWr}));
endmodule

// File: rtl/chip_select_decoder.sv
module chip_select_decoder
  import csdec_pkg::*;
#(
  parameter bit ERR_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdN,
  input  logic              wrN,
  output logic              romCsN,
  output logic              romOeN,
  output logic              ramCsN,
  output logic              ramOeN,
  output logic              ramWeN,
  output logic              inOeN,
  output logic              outWrN,
  output logic              errFlag
);
  ctrlT               ctrl;
  logic [NUM_DEV-1:0] hit;

  cs_datapath #(.ERR_EN(ERR_EN)) u_dp (
    .clk(clk), .rst(rst), .addr(addr), .ctrl(ctrl), .hit(hit), .errFlag(errFlag)
  );

  cs_control u_ctl (
    .clk(clk), .rst(rst), .hit(hit), .rdN(rdN), .wrN(wrN), .ctrl(ctrl)
  );

  assign romCsN = !ctrl.romCs;
  assign romOeN = !ctrl.romOe;
  assign ramCsN = !ctrl.ramCs;
  assign ramOeN = !ctrl.ramOe;
  assign ramWeN = !ctrl.ramWe;
  assign inOeN  = !ctrl.inOe;
  assign outWrN = !ctrl.outWr;

  assert_ram_we_only_write_R3: assert property (@(posedge clk) disable iff (rst)
    (!ramWeN) |-> (!wrN && rdN && addr[23:20] == 4'hA));
endmodule

// File: tb/chip_select_decoder_bench.sv
`timescale 1ns/100ps
module chip_select_decoder_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [23:0] addr = '0;
  logic rdN = 1'b1, wrN = 1'b1;
  logic romCsN, romOeN, ramCsN, ramOeN, ramWeN, inOeN, outWrN, errFlag;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  chip_select_decoder u_chip_select_decoder (
    .clk(clk), .rst(rst), .addr(addr), .rdN(rdN), .wrN(wrN),
    .romCsN(romCsN), .romOeN(romOeN), .ramCsN(ramCsN), .ramOeN(ramOeN),
    .ramWeN(ramWeN), .inOeN(inOeN), .outWrN(outWrN), .errFlag(errFlag)
  );

  // Expected {romCsN,romOeN,ramCsN,ramOeN,ramWeN,inOeN,outWrN} from R1..R7
  function automatic logic [6:0] expect_ctl(logic [23:0] a, logic r, logic w);
    logic rd, wr;
    logic [6:0] v;
    rd = !r && w;
    wr = r && !w;
    v = 7'h7F;
    if (a[23:16] == 8'h04 && rd) begin v[6] = 0; v[5] = 0; end
    if (a[23:20] == 4'hA && (rd || wr)) v[4] = 0;
    if (a[23:20] == 4'hA && rd) v[3] = 0;
    if (a[23:20] == 4'hA && wr) v[2] = 0;
    if (a[23:20] == 4'hF && a[7:0] == 8'h00 && rd) v[1] = 0;
    if (a[23:20] == 4'h1 && wr) v[0] = 0;
    return v;
  endfunction

  task automatic check_ctl(string tag);
    logic [6:0] act, exp;
    act = {romCsN, romOeN, ramCsN, ramOeN, ramWeN, inOeN, outWrN};
    exp = expect_ctl(addr, rdN, wrN);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h rdN=%b wrN=%b actual=%b expected=%b", tag, addr, rdN, wrN, act, exp);
    end
  endtask

  task automatic check_flag(string tag, logic exp);
    checks++;
    if (errFlag !== exp) begin
      errors++;
      $display("FAIL %s errFlag actual=%b expected=%b", tag, errFlag, exp);
    end
  endtask

  // Apply at a falling edge, sample 1 ns later
  task automatic access(logic [23:0] a, logic r, logic w, string tag);
    @(negedge clk);
    addr = a; rdN = r; wrN = w;
    #1 check_ctl(tag);
  endtask

  task automatic all_modes(logic [23:0] a, string tag);
    access(a, 0, 1, tag);
    access(a, 1, 0, tag);
    access(a, 1, 1, "R6");
    access(a, 0, 0, "R7");
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; rdN = 1; wrN = 1;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic t_reset();
    do_reset();
    #1 check_flag("R9 reset", 0);
    check_ctl("R6 reset");
  endtask

  task automatic t_rom();
    logic [23:0] pts [4] = '{24'h03FFFF, 24'h040000, 24'h04FFFF, 24'h050000};
    foreach (pts[i]) all_modes(pts[i], "R1 R2");
    access(24'h048123, 1, 0, "R2");
  endtask

  task automatic t_ram();
    logic [23:0] pts [5] = '{24'h9FFFFF, 24'hA00000, 24'hA5A5A5, 24'hAFFFFF, 24'hB00000};
    foreach (pts[i]) all_modes(pts[i], "R3");
  endtask

  task automatic t_inport();
    logic [23:0] pts [7] = '{24'hF00000, 24'hFFFF00, 24'hF5A300, 24'hF00001,
                             24'hF12380, 24'hEFFF00, 24'hFFFFFF};
    foreach (pts[i]) all_modes(pts[i], "R4");
  endtask

  task automatic t_outport();
    logic [23:0] pts [5] = '{24'h0FFFFF, 24'h100000, 24'h1ABCDE, 24'h1FFFFF, 24'h200000};
    foreach (pts[i]) all_modes(pts[i], "R5");
  endtask

  task automatic t_comb();
    // R10: changes between edges reach the outputs without a clock edge
    @(posedge clk); #0.5;
    addr = 24'h040010; rdN = 0; wrN = 1;
    #0.5 check_ctl("R10 rom");
    addr = 24'hA00010;
    #0.5 check_ctl("R10 ram");
    rdN = 1; wrN = 0;
    #0.5 check_ctl("R10 ram write");
    rdN = 1; wrN = 1;
  endtask

  task automatic t_flag();
    do_reset();
    access(24'h040000, 0, 1, "R9 mapped");
    @(posedge clk); #1 check_flag("R9 mapped read no set", 0);
    access(24'h1FFFFF, 1, 0, "R9 mapped");
    @(posedge clk); #1 check_flag("R9 mapped write no set", 0);
    access(24'h000000, 0, 1, "R9 unmapped");
    @(posedge clk); #1 check_flag("R9 set", 1);
    access(24'h000000, 1, 1, "R6");
    repeat (3) @(posedge clk);
    #1 check_flag("R9 sticky idle", 1);
    access(24'hA00000, 0, 1, "R3");
    @(posedge clk); #1 check_flag("R9 sticky mapped", 1);
    do_reset();
    #1 check_flag("R9 cleared", 0);
    access(24'hF00001, 1, 0, "R9 unmapped write");
    @(posedge clk); #1 check_flag("R9 set by write", 1);
  endtask

  initial begin
    t_reset();
    t_rom();
    t_ram();
    t_inport();
    t_outport();
    t_comb();
    t_flag();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule